// File: doc/BRIEF.md
# Frame CRC Strip and Retag Stage

This stage sits between a receive port and a frame-processing core that may edit frame payloads. Both sides carry the same token-framed byte stream. Each beat is either a data byte or a control token. The stage marks every frame as needing a fresh checksum and removes the old checksum bytes, so the core can change the payload freely. A later transmitter then rebuilds the checksum.

The stage cannot know which bytes are the last four of a frame until the end token arrives. It therefore holds the four most recent data bytes of the current frame in a short lookahead line. A data byte leaves the stage only when a newer byte arrives behind it and pushes it out. When the end token comes, the bytes still held are the checksum. They are discarded, and the lookahead line starts empty for the next frame.

Both sides use a valid/ready handshake, so the downstream core can stall the stage at any time.

Top module: `crc_strip_retag`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `out_valid` is 0. The first control token after reset is taken as a start-of-frame token.
- R2: Outside a frame, a control token (`in_ctl`=1) opens a frame. A start value of 3 (checksum attached) is emitted as a control token of value 0 (checksum needed). Any other start value is emitted unchanged.
- R3: Data bytes (`in_ctl`=0) inside a frame are emitted in arrival order with `out_ctl`=0. A byte is emitted only after four later data bytes of the same frame have been accepted.
- R4: The last four data bytes before a frame's end token are never emitted.
- R5: If a frame carried four or more data bytes, its end token is emitted with its value unchanged (for example 0 or 15).
- R6: If a frame carried fewer than four data bytes, the output frame holds only its start token and an end token of value 15.
- R7: While `out_valid` is 1 and `out_ready` is 0, the output beat stays unchanged. Every expected beat is delivered exactly once, with no loss and no repetition.
- R8: `in_ready` is 0 only when the offered beat would produce an output beat and the output register holds a beat that is not taken in that cycle. An output is produced by any control token, or by a data byte inside a frame while four bytes are held.
- R9: Data bytes that arrive outside a frame are accepted and produce no output.
- R10: An end token empties the lookahead line, so no byte of one frame appears in the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Stage accepts the offered beat this cycle |
| in_ctl | input | 1 | 1 = control token, 0 = data byte |
| in_data | input | 8 | Token value or data byte |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the output beat this cycle |
| out_ctl | output | 1 | 1 = control token, 0 = data byte |
| out_data | output | 8 | Token value or data byte |

## Verification
Two functions can fall in the same cycle. One is the flush of the lookahead line on an end token, together with the choice between the forwarded and the forced end value. The other is the hand-off of a beat the downstream side has been stalling. The bench provokes this overlap with random `out_ready` and `in_valid` patterns over many back-to-back frames of zero to twelve data bytes. Some frames are exactly four bytes long, and stray bytes are placed between frames.

A queue-based reference model judges every accepted output beat against the expected stream. It also checks `in_ready` on every cycle that offers a beat, and checks that a stalled beat is held unchanged.

// File: rtl/crc_strip_pkg.sv
package crc_strip_pkg;

    localparam int unsigned BYTE_W = 8;

    localparam logic [BYTE_W-1:0] TOK_SOF_WITH_CRC = 8'd3;
    localparam logic [BYTE_W-1:0] TOK_SOF_NEED_CRC = 8'd0;
    localparam logic [BYTE_W-1:0] TOK_EOF_SHORT    = 8'd15;

    typedef struct packed {
        logic              ctl;
        logic [BYTE_W-1:0] val;
    } beat_t;

    typedef enum logic {
        FR_IDLE = 1'b0,
        FR_BODY = 1'b1
    } frame_state_e;

    function automatic beat_t retag_sof(input beat_t b);
        beat_t r;
        r = b;
        if (b.val == TOK_SOF_WITH_CRC) r.val = TOK_SOF_NEED_CRC;
        return r;
    endfunction

    function automatic beat_t make_eof(input logic [BYTE_W-1:0] v, input logic long_enough);
        beat_t r;
        r.ctl = 1'b1;
        r.val = long_enough ? v : TOK_EOF_SHORT;
        return r;
    endfunction

endpackage

// File: rtl/cs_lookahead.sv
module cs_lookahead
    import crc_strip_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              clear,
    input  logic [BYTE_W-1:0] din,
    output logic              full,
    output logic [BYTE_W-1:0] head
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [BYTE_W-1:0] mem    [DEPTH];
    logic [BYTE_W-1:0] mem_nx [DEPTH];
    logic [CW-1:0]     count;

    assign full = (count == CW'(DEPTH));
    assign head = mem[0];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        if (i == DEPTH - 1) begin : g_tail
            assign mem_nx[i] = (push && (full || count == CW'(i))) ? din : mem[i];
        end else begin : g_body
            assign mem_nx[i] = !push                ? mem[i]   :
                               full                 ? mem[i+1] :
                               (count == CW'(i))    ? din      : mem[i];
        end
    end

    always_ff @(posedge clk) begin
        mem <= mem_nx;
    end

    always_ff @(posedge clk) begin
        if (rst || clear)        count <= '0;
        else if (push && !full)  count <= count + 1'b1;
    end

    p_no_overflow_r3 : assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    p_clear_empties_r10 : assert property (@(posedge clk) disable iff (rst)
        clear |=> !full);

endmodule

// File: rtl/cs_out_stage.sv
module cs_out_stage
    import crc_strip_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  beat_t             din,
    input  logic              out_ready,
    output logic              out_valid,
    output beat_t             dout
);
    always_ff @(posedge clk) begin
        if (rst)            out_valid <= 1'b0;
        else if (load)      out_valid <= 1'b1;
        else if (out_ready) out_valid <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (load) dout <= din;
    end

    p_hold_stable_r7 : assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(dout)));

    p_no_overwrite_r7 : assert property (@(posedge clk) disable iff (rst)
        load |-> (!out_valid || out_ready));

endmodule

// File: rtl/cs_frame_ctrl.sv
module cs_frame_ctrl
    import crc_strip_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  beat_t             in_beat,
    input  logic              slot_free,
    input  logic              la_full,
    input  logic [BYTE_W-1:0] la_head,
    output logic              in_ready,
    output logic              in_body,
    output logic              la_push,
    output logic              la_clear,
    output logic              emit_load,
    output beat_t             emit_beat
);
    frame_state_e state, state_nx;
    logic         needs_out;
    logic         accept;
    logic         push_c, clear_c;

    always_comb begin
        needs_out = 1'b0;
        push_c    = 1'b0;
        clear_c   = 1'b0;
        emit_beat = '0;
        state_nx  = state;
        if (state == FR_IDLE) begin
            if (in_beat.ctl) begin
                needs_out = 1'b1;
                emit_beat = retag_sof(in_beat);
                state_nx  = FR_BODY;
            end
        end else begin
            if (in_beat.ctl) begin
                needs_out = 1'b1;
                emit_beat = make_eof(in_beat.val, la_full);
                clear_c   = 1'b1;
                state_nx  = FR_IDLE;
            end else begin
                push_c = 1'b1;
                if (la_full) begin
                    needs_out = 1'b1;
                    emit_beat = '{ctl: 1'b0, val: la_head};
                end
            end
        end
    end

    assign in_ready  = !needs_out || slot_free;
    assign accept    = in_valid && in_ready;
    assign la_push   = accept && push_c;
    assign la_clear  = accept && clear_c;
    assign emit_load = accept && needs_out;
    assign in_body   = (state == FR_BODY);

    always_ff @(posedge clk) begin
        if (rst)         state <= FR_IDLE;
        else if (accept) state <= state_nx;
    end

endmodule

// File: rtl/crc_strip_retag.sv
module crc_strip_retag
    import crc_strip_pkg::*;
#(
    parameter int unsigned CRC_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_ctl,
    input  logic [BYTE_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_ctl,
    output logic [BYTE_W-1:0] out_data
);
    beat_t             in_beat, emit_beat, out_beat;
    logic              slot_free, la_full, la_push, la_clear, emit_load, in_body;
    logic [BYTE_W-1:0] la_head;

    assign in_beat   = '{ctl: in_ctl, val: in_data};
    assign slot_free = !out_valid || out_ready;

    cs_frame_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_beat   (in_beat),
        .slot_free (slot_free),
        .la_full   (la_full),
        .la_head   (la_head),
        .in_ready  (in_ready),
        .in_body   (in_body),
        .la_push   (la_push),
        .la_clear  (la_clear),
        .emit_load (emit_load),
        .emit_beat (emit_beat)
    );

    cs_lookahead #(.DEPTH(CRC_BYTES)) u_la (
        .clk   (clk),
        .rst   (rst),
        .push  (la_push),
        .clear (la_clear),
        .din   (in_data),
        .full  (la_full),
        .head  (la_head)
    );

    cs_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (emit_load),
        .din       (emit_beat),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .dout      (out_beat)
    );

    assign out_ctl  = out_beat.ctl;
    assign out_data = out_beat.val;

    logic acc;
    assign acc = in_valid && in_ready;

    p_reset_quiet_r1 : assert property (@(posedge clk)
        rst |=> !out_valid);

    p_sof_retag_r2 : assert property (@(posedge clk) disable iff (rst)
        (acc && in_ctl && !in_body && in_data == TOK_SOF_WITH_CRC)
        |=> (out_valid && out_ctl && out_data == TOK_SOF_NEED_CRC));

    p_eof_forward_r5 : assert property (@(posedge clk) disable iff (rst)
        (acc && in_ctl && in_body && la_full)
        |=> (out_valid && out_ctl && out_data == $past(in_data)));

    p_eof_short_r6 : assert property (@(posedge clk) disable iff (rst)
        (acc && in_ctl && in_body && !la_full)
        |=> (out_valid && out_ctl && out_data == TOK_EOF_SHORT));

    p_silent_accept_r9 : assert property (@(posedge clk) disable iff (rst)
        (acc && !in_ctl && !(in_body && la_full) && slot_free) |=> !out_valid);

endmodule

// File: tb/tb_crc_strip_retag.sv
module tb_crc_strip_retag;
    import crc_strip_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0, in_ctl = 1'b0, out_ready = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready, out_valid, out_ctl;
    logic [7:0] out_data;

    always #2 clk = ~clk;

    crc_strip_retag dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_ctl(in_ctl), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_ctl(out_ctl), .out_data(out_data)
    );

    int compared = 0;
    int mismatched = 0;

    logic [8:0] stim_q [$];
    logic [8:0] exp_q  [$];
    string      tag_q  [$];
    int         hold_q [$];
    bit         mdl_body = 0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    task automatic add_frame(input logic [7:0] sof, input int n, input logic [7:0] eof);
        stim_q.push_back({1'b1, sof});
        for (int i = 0; i < n; i++) stim_q.push_back({1'b0, 8'($urandom)});
        stim_q.push_back({1'b1, eof});
    endtask

    task automatic model_accept(input logic [8:0] b);
        if (!mdl_body) begin
            if (b[8]) begin
                exp_q.push_back({1'b1, (b[7:0] == 8'd3) ? 8'd0 : b[7:0]});
                tag_q.push_back("R2");
                mdl_body = 1;
            end
            // R9: stray data outside a frame yields nothing
        end else if (b[8]) begin
            exp_q.push_back({1'b1, (hold_q.size() == 4) ? b[7:0] : 8'd15});
            tag_q.push_back((hold_q.size() == 4) ? "R5" : "R6");
            hold_q.delete();   // R10: nothing carries into the next frame
            mdl_body = 0;
        end else begin
            hold_q.push_back(int'(b[7:0]));
            if (hold_q.size() > 4) begin
                exp_q.push_back({1'b0, 8'(hold_q.pop_front())});
                tag_q.push_back("R3");
            end
        end
    endtask

    initial begin
        logic [8:0] pend;
        bit         have = 0;
        bit         prev_hold = 0;
        logic [8:0] held = '0;
        int         cyc = 0;
        int         idle = 0;
        bit         need;

        // directed frames
        add_frame(8'd3, 0, 8'd0);   // R6 empty
        add_frame(8'd3, 3, 8'd0);   // R6 short, end forced to 15
        add_frame(8'd3, 4, 8'd0);   // R4/R5 exactly the checksum
        add_frame(8'd3, 5, 8'd15);  // one payload byte
        stim_q.push_back({1'b0, 8'hA5});   // R9 stray
        stim_q.push_back({1'b0, 8'h5A});
        add_frame(8'd0, 6, 8'd0);   // R2 non-3 start unchanged
        add_frame(8'd7, 9, 8'd15);
        for (int f = 0; f < 300; f++) begin
            if ($urandom % 6 == 0) stim_q.push_back({1'b0, 8'($urandom)});
            add_frame(($urandom % 4 == 0) ? 8'd0 : 8'd3, $urandom % 13,
                      ($urandom % 2 == 0) ? 8'd0 : 8'd15);
        end

        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R1 out_valid in reset", out_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(out_valid === 1'b0, "R1 out_valid after reset", out_valid, 0);

        while (cyc < 100000) begin
            @(negedge clk);
            cyc++;
            if (!have && stim_q.size() > 0) begin
                pend = stim_q.pop_front();
                have = 1;
            end
            in_valid  = have && ($urandom % 4 != 0);
            {in_ctl, in_data} = pend;
            out_ready = (cyc > 2000 && cyc < 2400) ? 1'b1 : ($urandom % 3 != 0);
            #1;
            if (prev_hold)
                check(out_valid && {out_ctl, out_data} == held, "R7 stalled beat held",
                      {out_valid, out_ctl, out_data}, {1'b1, held});
            prev_hold = out_valid && !out_ready;
            held      = {out_ctl, out_data};
            if (in_valid) begin
                need = in_ctl || (mdl_body && !in_ctl && hold_q.size() == 4);
                check(in_ready === (!need || !out_valid || out_ready), "R8 in_ready",
                      in_ready, (!need || !out_valid || out_ready));
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R4 unexpected extra beat", {out_ctl, out_data}, 0);
                end else begin
                    logic [8:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({out_ctl, out_data} == e, t, {out_ctl, out_data}, e);
                end
            end
            if (in_valid && in_ready) begin
                model_accept(pend);
                have = 0;
            end
            if (!have && stim_q.size() == 0 && exp_q.size() == 0 && !out_valid) begin
                idle++;
                if (idle > 10) break;
            end
        end
        if (cyc >= 100000) begin
            mismatched++;
            $display("FAIL watchdog R7 actual=%0d expected=%0d", exp_q.size(), 0);
        end
        check(exp_q.size() == 0, "R7 all beats delivered", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule